// File: doc/BRIEF.md
# PHY Link-Request Serial Encoder

This block sits between the link layer and the physical layer of a serial bus node. It takes requests that the link presents in parallel on three request ports and turns each one into a framed bit stream. The stream goes out on a single serial line, one bit per clock. The three ports are:

- Bus arbitration, in a short form or an extended form.
- Register access, either a read or a write.
- Arbitration-acceleration control, which the link uses to turn acceleration on or off for a while during the asynchronous period.

Each stream opens with a start bit of 1 and closes with a stop bit of 0. A 3-bit request-type field follows the start bit, and a payload follows the type field. The payload length depends on the request kind, so streams are 6, 7, 8, 9 or 17 bits long. Each port has a valid input and a one-cycle taken output. A shared busy output tells the link when the serial line is occupied. When more than one port is pending, a fixed priority decides which request is taken next.

Top module: `phy_req_serializer`

## Requirements
- R1: After reset, and in every cycle outside a stream, `ser_out` and `busy` are 0.
- R2: Every stream begins with a 1 bit and ends with a 0 bit.
- R3: The three bits after the start bit carry the type code. The codes are: 000 immediate, 001 isochronous, 010 priority, 011 fair, 100 register read, 101 register write, 110 acceleration control. For bus requests the code is 0 followed by `bus_kind`.
- R4: A short bus request (`bus_ext`=0) is 7 bits: start, type, `bus_speed[1:0]`, stop.
- R5: An extended bus request (`bus_ext`=1) is 8 bits: start, type, `bus_speed[2:0]`, stop.
- R6: A register read is 9 bits: start, 100, the 4-bit address, stop.
- R7: A register write is 17 bits: start, 101, the 4-bit address, the 8 data bits, stop.
- R8: An acceleration control request is 6 bits: start, 110, `acc_enable`, stop.
- R9: Fields are sent most significant bit first, one bit per clock. A request is taken at the clock edge where its taken output is high. The start bit appears in the next cycle, and `busy` stays high for exactly the stream length.
- R10: When several ports are valid, the register port wins, then the acceleration port, then the bus port. At most one taken output is high at a time, and only while `busy` is low.
- R11: A new stream starts only after the previous stop bit, with at least one idle cycle between streams. A request that arrives while `busy` is high waits for that gap.
- R12: In the short bus form, `bus_speed[2]` has no effect on the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus arbitration request pending |
| bus_kind | input | 2 | Arbitration kind: 0 immediate, 1 isochronous, 2 priority, 3 fair |
| bus_ext | input | 1 | Selects the extended form with a 3-bit speed |
| bus_speed | input | 3 | Requested speed code |
| bus_taken | output | 1 | Bus request accepted this cycle |
| reg_valid | input | 1 | Register access pending |
| reg_write | input | 1 | 1 selects write, 0 selects read |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_taken | output | 1 | Register request accepted this cycle |
| acc_valid | input | 1 | Acceleration control pending |
| acc_enable | input | 1 | 1 turns acceleration on, 0 turns it off |
| acc_taken | output | 1 | Acceleration request accepted this cycle |
| busy | output | 1 | A stream is being sent |
| ser_out | output | 1 | Serial request line |

## Verification
The taken outputs are combinational: a request is seen as taken in the same cycle it is offered while the line is idle. The start bit then appears one clock later, and each further bit follows one clock after that. The driver samples the taken output a short delay after it drives its inputs, and only then pushes the expected stream onto the scoreboard. The monitor samples `busy` and `ser_out` on the falling edge. It collects bits for as long as `busy` is high, and compares the finished stream and its length when `busy` falls. It also checks that the line is at 0 in the gap cycle after each stream.

// File: rtl/phy_req_serializer.sv
module phy_req_serializer #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic [1:0]        bus_kind,
  input  logic              bus_ext,
  input  logic [2:0]        bus_speed,
  output logic              bus_taken,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic              reg_taken,
  input  logic              acc_valid,
  input  logic              acc_enable,
  output logic              acc_taken,
  output logic              busy,
  output logic              ser_out
);

  localparam int FRAME_W = 1 + 3 + ADDR_W + DATA_W + 1;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam int RD_LEN  = 1 + 3 + ADDR_W + 1;
  localparam logic [2:0] T_READ  = 3'b100;
  localparam logic [2:0] T_WRITE = 3'b101;
  localparam logic [2:0] T_ACCEL = 3'b110;

  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   left;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   frame_len;

  assign busy      = (left != '0);
  assign ser_out   = busy & shreg[FRAME_W-1];
  assign reg_taken = reg_valid & ~busy;
  assign acc_taken = acc_valid & ~reg_valid & ~busy;
  assign bus_taken = bus_valid & ~acc_valid & ~reg_valid & ~busy;

  always_comb begin
    frame     = '0;
    frame_len = '0;
    if (reg_valid && reg_write) begin
      frame     = {1'b1, T_WRITE, reg_addr, reg_wdata, 1'b0};
      frame_len = CNT_W'(FRAME_W);
    end else if (reg_valid) begin
      frame     = FRAME_W'({1'b1, T_READ, reg_addr, 1'b0}) << (FRAME_W - RD_LEN);
      frame_len = CNT_W'(RD_LEN);
    end else if (acc_valid) begin
      frame     = FRAME_W'({1'b1, T_ACCEL, acc_enable, 1'b0}) << (FRAME_W - 6);
      frame_len = CNT_W'(6);
    end else if (bus_ext) begin
      frame     = FRAME_W'({1'b1, 1'b0, bus_kind, bus_speed, 1'b0}) << (FRAME_W - 8);
      frame_len = CNT_W'(8);
    end else begin
      frame     = FRAME_W'({1'b1, 1'b0, bus_kind, bus_speed[1:0], 1'b0}) << (FRAME_W - 7);
      frame_len = CNT_W'(7);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '0;
      left  <= '0;
    end else if (busy) begin
      shreg <= shreg << 1;
      left  <= left - 1'b1;
    end else if (reg_valid || acc_valid || bus_valid) begin
      shreg <= frame;
      left  <= frame_len;
    end
  end

  assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ser_out);

  assert_start_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ser_out);

  assert_stop_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !$past(ser_out));

  assert_take_starts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_taken || acc_taken || bus_taken) |=> busy);

  assert_one_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_taken, acc_taken, bus_taken}));

  assert_reg_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && !busy) |-> (reg_taken && !acc_taken && !bus_taken));

  assert_no_grant_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(reg_taken || acc_taken || bus_taken));

endmodule

// File: tb/phy_req_serializer_bench.sv
module phy_req_serializer_bench;
  logic clk = 0;
  logic rst_n = 0;
  logic bus_valid = 0, bus_ext = 0, reg_valid = 0, reg_write = 0, acc_valid = 0, acc_enable = 0;
  logic [1:0] bus_kind = 0;
  logic [2:0] bus_speed = 0;
  logic [3:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic bus_taken, reg_taken, acc_taken, busy, ser_out;

  int tests = 0, fails = 0;
  logic [31:0] exp_val[$];
  int          exp_len[$];
  string       exp_tag[$];
  time t_reg, t_acc, t_bus;

  always #10 clk = ~clk;

  phy_req_serializer u_phy_req_serializer (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_kind(bus_kind), .bus_ext(bus_ext), .bus_speed(bus_speed),
    .bus_taken(bus_taken),
    .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_taken(reg_taken),
    .acc_valid(acc_valid), .acc_enable(acc_enable), .acc_taken(acc_taken),
    .busy(busy), .ser_out(ser_out));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic push(string tag, logic [31:0] v, int n);
    exp_val.push_back(v);
    exp_len.push_back(n);
    exp_tag.push_back(tag);
  endtask

  task automatic post_bus(logic [1:0] kind, logic ext, logic [2:0] spd, string tag);
    logic [31:0] v;
    int n;
    @(negedge clk);
    bus_kind = kind; bus_ext = ext; bus_speed = spd; bus_valid = 1;
    v = {29'd0, 1'b1, 1'b0, kind[1]};
    v = (v << 1) | 32'(kind[0]);
    if (ext) begin v = (v << 3) | 32'(spd); n = 8; end
    else begin v = (v << 2) | 32'(spd[1:0]); n = 7; end
    v = v << 1;
    forever begin #1; if (bus_taken) break; @(negedge clk); end
    push(tag, v, n);
    t_bus = $time;
    @(negedge clk);
    bus_valid = 0;
  endtask

  task automatic post_reg(logic wr, logic [3:0] a, logic [7:0] d, string tag);
    logic [31:0] v;
    int n;
    @(negedge clk);
    reg_write = wr; reg_addr = a; reg_wdata = d; reg_valid = 1;
    if (wr) begin v = {15'd0, 1'b1, 3'b101, a, d, 1'b0}; n = 17; end
    else begin v = {23'd0, 1'b1, 3'b100, a, 1'b0}; n = 9; end
    forever begin #1; if (reg_taken) break; @(negedge clk); end
    push(tag, v, n);
    t_reg = $time;
    @(negedge clk);
    reg_valid = 0;
  endtask

  task automatic post_acc(logic en, string tag);
    @(negedge clk);
    acc_enable = en; acc_valid = 1;
    forever begin #1; if (acc_taken) break; @(negedge clk); end
    push(tag, {26'd0, 1'b1, 3'b110, en, 1'b0}, 6);
    t_acc = $time;
    @(negedge clk);
    acc_valid = 0;
  endtask

  task automatic drain();
    int k = 0;
    while ((exp_val.size() != 0 || busy) && k < 200) begin @(negedge clk); k++; end
    repeat (3) @(negedge clk);
  endtask

  // monitor: collect the stream while busy, compare when busy falls
  initial begin
    logic [31:0] cap;
    int cnt;
    logic was_busy;
    cap = 0; cnt = 0; was_busy = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (busy) begin
          cap = (cap << 1) | 32'(ser_out);
          cnt++;
        end else if (was_busy) begin
          check("R1 gap line idle", 32'(ser_out), 32'd0);
          if (exp_val.size() == 0) begin
            check("R11 unexpected stream", 32'(cnt), 32'd0);
          end else begin
            string tg;
            tg = exp_tag.pop_front();
            check({tg, " length R9"}, 32'(cnt), 32'(exp_len.pop_front()));
            check({tg, " bits R2 R3"}, cap, exp_val.pop_front());
          end
          cap = 0; cnt = 0;
        end
        was_busy = busy;
      end
    end
  end

  initial begin
    #1500000;
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset busy", 32'(busy), 0);
    check("R1 reset line", 32'(ser_out), 0);

    post_acc(1'b1, "R8 accel on");   drain();
    post_acc(1'b0, "R8 accel off");  drain();
    post_bus(2'd1, 1'b0, 3'b101, "R4 R12 short iso spd2 ignored"); drain();
    post_bus(2'd0, 1'b0, 3'b010, "R4 short immediate"); drain();
    post_bus(2'd3, 1'b1, 3'b110, "R5 ext fair"); drain();
    post_bus(2'd2, 1'b1, 3'b001, "R5 ext priority"); drain();
    post_reg(1'b0, 4'hA, 8'h00, "R6 read A"); drain();
    post_reg(1'b1, 4'h5, 8'hA5, "R7 write 5"); drain();
    post_reg(1'b1, 4'hF, 8'h00, "R7 write F zero"); drain();

    fork
      post_bus(2'd3, 1'b0, 3'b011, "R10 bus last");
      post_reg(1'b0, 4'h3, 8'h00, "R10 reg first");
      post_acc(1'b1, "R10 accel second");
    join
    drain();
    check("R10 reg before accel", 32'(t_reg < t_acc), 1);
    check("R10 accel before bus", 32'(t_acc < t_bus), 1);

    fork
      post_reg(1'b1, 4'h9, 8'h3C, "R11 first");
      begin repeat (3) @(negedge clk); post_bus(2'd1, 1'b1, 3'b100, "R11 waiting bus"); end
    join
    drain();
    check("R11 waiter after first", 32'(t_bus > t_reg + 17 * 20), 1);
    check("R1 final idle", 32'(busy | ser_out), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule